// File: doc/BRIEF.md
# SMBus Transaction Register Front End

This block presents an SMBus host controller to software as a small byte-addressed register file. Software fills in the target address, the command byte, an optional byte count and up to 32 data bytes. It then writes a protocol byte, and that write starts a transaction. The bit-level bus engine sits outside the block behind a simple handshake. The block gives that engine a one-cycle start request carrying the protocol, device address, command and transfer length. While the request is open, the engine reads outgoing bytes from the data window by index. It writes returned bytes back by index and finishes with a done pulse, a completion code and a received length.

The status byte reports progress. Its done flag clears when a transaction starts and sets when a result arrives, and its low five bits carry the completion code. Two cases are answered locally, with no start request issued: a protocol write that arrives while a transaction is already running, and a protocol code the block does not recognise.

Top module: `smbfront_top`

## Requirements
- R1: After reset the status byte (offset 0x01) reads 0x00, the byte count (offset 0x24) reads 0, `busy` is low and no start request is issued.
- R2: Writing a supported code to the protocol register (offset 0x00) while idle clears the status byte to 0x00. In the next cycle, `mstStart` is high with `mstProto` equal to the written byte, `mstDevAddr` equal to bits 7:1 of the address register (offset 0x02) and `mstCmd` equal to the command register (offset 0x03).
- R3: `mstStart` is high for exactly one cycle per accepted launch and never rises again before the running transaction completes.
- R4: A `mstDone` pulse while busy makes the status byte read bit 7 set with `mstCode` in bits 4:0 from the next cycle on, and drops `busy`.
- R5: A received byte (`mstRxValid`) with index i while busy appears at offset 0x04+i. A word result is therefore little-endian, with the low byte at 0x04 and the high byte at 0x05.
- R6: On completion of a block read (protocol bits 6:0 equal to 0x0B) or a block process call (0x0D), the byte count takes min(`mstRxLen`, 32). Completion of any other protocol leaves the count unchanged.
- R7: A host write to the byte count stores min(value, 32).
- R8: `mstLen` equals the byte count, except that for a block process call it is limited to 31.
- R9: A protocol write while busy is rejected. It issues no start, leaves the protocol register unchanged and sets the completion code to 0x1A with done still clear.
- R10: A protocol write while idle whose code (bits 6:0, with bit 0 ignored except for 0x0D) is none of 0x02, 0x04, 0x06, 0x08, 0x0A, 0x0C, 0x0D or 0x4A is stored, issues no start, and sets the status byte to 0x99 at once.
- R11: Host writes to the status byte are ignored, and received bytes presented while idle do not alter the data window.
- R12: The alarm address (0x25) and the two alarm data bytes (0x26, 0x27) read back what was written, and status bit 6 reads 0.
- R13: `mstTxByte` shows the data byte at offset 0x04 + `mstTxIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Register write strobe |
| hostAddr | input | 6 | Register byte offset |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Read data for hostAddr (combinational) |
| busy | output | 1 | A transaction is in flight |
| mstStart | output | 1 | One-cycle start request to the bus engine |
| mstProto | output | 8 | Protocol byte of the request |
| mstDevAddr | output | 7 | 7-bit target address |
| mstCmd | output | 8 | Command byte |
| mstLen | output | 6 | Transfer length for block protocols |
| mstTxIdx | input | 5 | Index of the outgoing byte requested |
| mstTxByte | output | 8 | Outgoing byte at mstTxIdx |
| mstRxValid | input | 1 | Received byte strobe |
| mstRxIdx | input | 5 | Index of the received byte |
| mstRxByte | input | 8 | Received byte |
| mstDone | input | 1 | Transaction completion pulse |
| mstCode | input | 5 | Completion code |
| mstRxLen | input | 8 | Byte count reported by the target |

## Verification
If the control state is wrong, the status byte or `mstStart` shows it within one cycle of the triggering write or completion. A stuck busy state turns into a 0x1A code on the next protocol write. A lost busy state turns into an extra start request, and the start scoreboard reports that as unexpected. Faults in the datapath show up at the next readback of the affected offset: a misplaced received byte, a count that is not clamped, or a wrongly decoded block-read kind. `mstLen` is compared at every start, which catches a missing 31-byte limit as soon as the block process call launches.

// File: rtl/smbfront_pkg.sv
package smbfront_pkg;

  typedef struct packed {
    logic       protoLoad;
    logic       statusClear;
    logic       statusSet;
    logic       codeOnly;
    logic [4:0] code;
    logic       countCapture;
  } ctrlStrobe_t;

  localparam logic [4:0] CODE_BUSY   = 5'h1A;
  localparam logic [4:0] CODE_NOTSUP = 5'h19;

  localparam int OFS_PROTO  = 0;
  localparam int OFS_STATUS = 1;
  localparam int OFS_ADDR   = 2;
  localparam int OFS_CMD    = 3;
  localparam int OFS_DATA   = 4;

  function automatic logic protoSupported(input logic [7:0] p);
    logic [6:0] base;
    base = {p[6:1], 1'b0};
    if (p[6:0] == 7'h0D) return 1'b1;
    case (base)
      7'h02, 7'h04, 7'h06, 7'h08, 7'h0A, 7'h0C, 7'h4A: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic protoBlockProc(input logic [7:0] p);
    return p[6:0] == 7'h0D;
  endfunction

  function automatic logic protoBlockRead(input logic [7:0] p);
    return (p[6:0] == 7'h0B) || (p[6:0] == 7'h0D);
  endfunction

endpackage

// File: rtl/smbfront_ctrl.sv
module smbfront_ctrl
  import smbfront_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        protoWr,
  input  logic [7:0]  protoWrData,
  input  logic [7:0]  protoNow,
  input  logic        mstDone,
  input  logic [4:0]  mstCode,
  output ctrlStrobe_t stb,
  output logic        busy,
  output logic        mstStart
);

  logic launch;

  assign launch = !busy && protoWr && protoSupported(protoWrData);

  always_comb begin
    stb = '0;
    if (busy) begin
      if (mstDone) begin
        stb.statusSet    = 1'b1;
        stb.code         = mstCode;
        stb.countCapture = protoBlockRead(protoNow);
      end else if (protoWr) begin
        stb.codeOnly = 1'b1;
        stb.code     = CODE_BUSY;
      end
    end else if (protoWr) begin
      stb.protoLoad = 1'b1;
      if (protoSupported(protoWrData)) begin
        stb.statusClear = 1'b1;
      end else begin
        stb.statusSet = 1'b1;
        stb.code      = CODE_NOTSUP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      mstStart <= 1'b0;
    end else begin
      mstStart <= launch;
      if (launch) busy <= 1'b1;
      else if (busy && mstDone) busy <= 1'b0;
    end
  end

  // R3: a start pulse lasts one cycle
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    mstStart |=> !mstStart);

  // R3: a start only occurs while a transaction is open
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    mstStart |-> busy);

  // R4: completion releases busy
  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mstDone) |=> !busy);

  // R10: unsupported code never launches
  p_unsup_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && protoWr && !protoSupported(protoWrData)) |=> (!mstStart && !busy));

endmodule

// File: rtl/smbfront_regs.sv
module smbfront_regs
  import smbfront_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int AW         = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   stb,
  input  logic                          busy,
  input  logic                          hostWr,
  input  logic [AW-1:0]                 hostAddr,
  input  logic [7:0]                    hostWrData,
  output logic [7:0]                    hostRdData,
  output logic [7:0]                    protoNow,
  output logic [6:0]                    mstDevAddr,
  output logic [7:0]                    mstCmd,
  output logic [$clog2(DATA_BYTES+1)-1:0] mstLen,
  input  logic [$clog2(DATA_BYTES)-1:0] mstTxIdx,
  output logic [7:0]                    mstTxByte,
  input  logic                          mstRxValid,
  input  logic [$clog2(DATA_BYTES)-1:0] mstRxIdx,
  input  logic [7:0]                    mstRxByte,
  input  logic [7:0]                    mstRxLen
);

  localparam int IDX_W     = $clog2(DATA_BYTES);
  localparam int CNT_W     = $clog2(DATA_BYTES + 1);
  localparam int OFS_COUNT = OFS_DATA + DATA_BYTES;
  localparam int OFS_ALRMA = OFS_COUNT + 1;
  localparam int OFS_ALRMD = OFS_COUNT + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DATA_BYTES);
  localparam logic [CNT_W-1:0] PROC_MAX = CNT_W'(DATA_BYTES - 1);

  logic [7:0]       protoReg, addrReg, cmdReg, alarmAddr;
  logic [7:0]       alarmData [2];
  logic [CNT_W-1:0] countReg;
  logic             statusDone;
  logic [4:0]       statusCode;
  logic [7:0]       dataMem [DATA_BYTES];

  logic             inData;
  logic [AW-1:0]    dataOff;
  logic [IDX_W-1:0] hostIdx;

  function automatic logic [CNT_W-1:0] clampCount(input logic [7:0] v);
    return (v > 8'(DATA_BYTES)) ? CNT_MAX : v[CNT_W-1:0];
  endfunction

  assign dataOff = hostAddr - AW'(OFS_DATA);
  assign hostIdx = dataOff[IDX_W-1:0];
  assign inData  = (hostAddr >= AW'(OFS_DATA)) && (hostAddr < AW'(OFS_COUNT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoReg   <= '0;
      addrReg    <= '0;
      cmdReg     <= '0;
      countReg   <= '0;
      alarmAddr  <= '0;
      alarmData  <= '{default: '0};
      statusDone <= 1'b0;
      statusCode <= '0;
    end else begin
      if (stb.protoLoad) protoReg <= hostWrData;
      if (stb.statusClear) begin
        statusDone <= 1'b0;
        statusCode <= '0;
      end else if (stb.statusSet) begin
        statusDone <= 1'b1;
        statusCode <= stb.code;
      end else if (stb.codeOnly) begin
        statusCode <= stb.code;
      end
      if (hostWr) begin
        if (hostAddr == AW'(OFS_ADDR))  addrReg   <= hostWrData;
        if (hostAddr == AW'(OFS_CMD))   cmdReg    <= hostWrData;
        if (hostAddr == AW'(OFS_ALRMA)) alarmAddr <= hostWrData;
        if (hostAddr == AW'(OFS_ALRMD))     alarmData[0] <= hostWrData;
        if (hostAddr == AW'(OFS_ALRMD + 1)) alarmData[1] <= hostWrData;
      end
      if (stb.countCapture) countReg <= clampCount(mstRxLen);
      else if (hostWr && hostAddr == AW'(OFS_COUNT)) countReg <= clampCount(hostWrData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DATA_BYTES; i++) dataMem[i] <= '0;
    end else begin
      if (hostWr && inData) dataMem[hostIdx] <= hostWrData;
      if (busy && mstRxValid) dataMem[mstRxIdx] <= mstRxByte;
    end
  end

  always_comb begin
    hostRdData = '0;
    if (inData) hostRdData = dataMem[hostIdx];
    else if (hostAddr == AW'(OFS_PROTO))  hostRdData = protoReg;
    else if (hostAddr == AW'(OFS_STATUS)) hostRdData = {statusDone, 2'b00, statusCode};
    else if (hostAddr == AW'(OFS_ADDR))   hostRdData = addrReg;
    else if (hostAddr == AW'(OFS_CMD))    hostRdData = cmdReg;
    else if (hostAddr == AW'(OFS_COUNT))  hostRdData = 8'(countReg);
    else if (hostAddr == AW'(OFS_ALRMA))  hostRdData = alarmAddr;
    else if (hostAddr == AW'(OFS_ALRMD))     hostRdData = alarmData[0];
    else if (hostAddr == AW'(OFS_ALRMD + 1)) hostRdData = alarmData[1];
  end

  assign protoNow   = protoReg;
  assign mstDevAddr = addrReg[7:1];
  assign mstCmd     = cmdReg;
  assign mstTxByte  = dataMem[mstTxIdx];
  assign mstLen     = (protoBlockProc(protoReg) && countReg > PROC_MAX) ? PROC_MAX : countReg;

  // R7: stored count never exceeds the window
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    countReg <= CNT_MAX);

  // R9: a rejected launch reports busy with done clear
  p_busy_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.codeOnly |=> (statusCode == CODE_BUSY && !statusDone));

  // R2: a launch clears the status byte
  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.statusClear |=> (!statusDone && statusCode == 5'h00));

endmodule

// File: rtl/smbfront_top.sv
module smbfront_top
  import smbfront_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int AW         = 6,
  localparam int IDX_W     = $clog2(DATA_BYTES),
  localparam int CNT_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWr,
  input  logic [AW-1:0]    hostAddr,
  input  logic [7:0]       hostWrData,
  output logic [7:0]       hostRdData,
  output logic             busy,
  output logic             mstStart,
  output logic [7:0]       mstProto,
  output logic [6:0]       mstDevAddr,
  output logic [7:0]       mstCmd,
  output logic [CNT_W-1:0] mstLen,
  input  logic [IDX_W-1:0] mstTxIdx,
  output logic [7:0]       mstTxByte,
  input  logic             mstRxValid,
  input  logic [IDX_W-1:0] mstRxIdx,
  input  logic [7:0]       mstRxByte,
  input  logic             mstDone,
  input  logic [4:0]       mstCode,
  input  logic [7:0]       mstRxLen
);

  ctrlStrobe_t stb;
  logic [7:0]  protoNow;
  logic        protoWr;

  assign protoWr  = hostWr && (hostAddr == AW'(OFS_PROTO));
  assign mstProto = protoNow;

  smbfront_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .protoWr(protoWr), .protoWrData(hostWrData),
    .protoNow(protoNow), .mstDone(mstDone), .mstCode(mstCode),
    .stb(stb), .busy(busy), .mstStart(mstStart)
  );

  smbfront_regs #(.DATA_BYTES(DATA_BYTES), .AW(AW)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .hostWr(hostWr), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .protoNow(protoNow), .mstDevAddr(mstDevAddr),
    .mstCmd(mstCmd), .mstLen(mstLen), .mstTxIdx(mstTxIdx), .mstTxByte(mstTxByte),
    .mstRxValid(mstRxValid), .mstRxIdx(mstRxIdx), .mstRxByte(mstRxByte),
    .mstRxLen(mstRxLen)
  );

endmodule

// File: tb/smbfront_top_tb.sv
module smbfront_top_tb;

  typedef struct {
    logic [5:0] a;
    logic [7:0] e;
    string      tag;
  } rdItem_t;

  typedef struct {
    logic [7:0] proto;
    logic [6:0] dev;
    logic [7:0] cmd;
    logic [5:0] len;
    string      tag;
  } stItem_t;

  logic       clk = 0;
  logic       rstN = 0;
  logic       hostWr = 0;
  logic [5:0] hostAddr = 0;
  logic [7:0] hostWrData = 0;
  logic [7:0] hostRdData;
  logic       busy, mstStart;
  logic [7:0] mstProto, mstCmd;
  logic [6:0] mstDevAddr;
  logic [5:0] mstLen;
  logic [4:0] mstTxIdx = 0;
  logic [7:0] mstTxByte;
  logic       mstRxValid = 0;
  logic [4:0] mstRxIdx = 0;
  logic [7:0] mstRxByte = 0;
  logic       mstDone = 0;
  logic [4:0] mstCode = 0;
  logic [7:0] mstRxLen = 0;
  logic       rdReq = 0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  rdItem_t rdQ[$];
  stItem_t stQ[$];

  always #2 clk = ~clk;

  smbfront_top u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .busy(busy),
    .mstStart(mstStart), .mstProto(mstProto), .mstDevAddr(mstDevAddr),
    .mstCmd(mstCmd), .mstLen(mstLen), .mstTxIdx(mstTxIdx), .mstTxByte(mstTxByte),
    .mstRxValid(mstRxValid), .mstRxIdx(mstRxIdx), .mstRxByte(mstRxByte),
    .mstDone(mstDone), .mstCode(mstCode), .mstRxLen(mstRxLen)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic [5:0] a, logic [7:0] d);
    @(posedge clk); #1;
    hostWr = 1; hostAddr = a; hostWrData = d;
    @(posedge clk); #1;
    hostWr = 0;
  endtask

  task automatic expectRead(logic [5:0] a, logic [7:0] e, string tag);
    rdItem_t it;
    it.a = a; it.e = e; it.tag = tag;
    @(posedge clk); #1;
    rdQ.push_back(it);
    hostAddr = a; rdReq = 1;
    @(posedge clk); #1;
    rdReq = 0;
  endtask

  task automatic expectStart(logic [7:0] p, logic [6:0] d, logic [7:0] c,
                             logic [5:0] l, string tag);
    stItem_t it;
    it.proto = p; it.dev = d; it.cmd = c; it.len = l; it.tag = tag;
    stQ.push_back(it);
  endtask

  task automatic rxByte(logic [4:0] i, logic [7:0] b);
    @(posedge clk); #1;
    mstRxValid = 1; mstRxIdx = i; mstRxByte = b;
    @(posedge clk); #1;
    mstRxValid = 0;
  endtask

  task automatic finish(logic [4:0] code, logic [7:0] len);
    @(posedge clk); #1;
    mstDone = 1; mstCode = code; mstRxLen = len;
    @(posedge clk); #1;
    mstDone = 0;
  endtask

  // read monitor
  always @(negedge clk) begin
    if (rdReq && rdQ.size() > 0) begin
      rdItem_t it;
      it = rdQ.pop_front();
      check(it.tag, 32'(hostRdData), 32'(it.e));
    end
  end

  // start monitor
  always @(negedge clk) begin
    if (rstN && mstStart) begin
      if (stQ.size() == 0) begin
        check("R3/R9/R10 unexpected start", 1, 0);
      end else begin
        stItem_t it;
        it = stQ.pop_front();
        check({it.tag, " proto"}, 32'(mstProto), 32'(it.proto));
        check({it.tag, " dev"}, 32'(mstDevAddr), 32'(it.dev));
        check({it.tag, " cmd"}, 32'(mstCmd), 32'(it.cmd));
        check({it.tag, " len"}, 32'(mstLen), 32'(it.len));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    expectRead(6'h01, 8'h00, "R1 status");
    expectRead(6'h24, 8'h00, "R1 count");
    check("R1 busy", 32'(busy), 0);

    // R2 R13 word write
    hostWrite(6'h02, 8'hA4);
    hostWrite(6'h03, 8'h10);
    hostWrite(6'h04, 8'h34);
    hostWrite(6'h05, 8'h12);
    expectStart(8'h08, 7'h52, 8'h10, 6'd0, "R2 word write");
    hostWrite(6'h00, 8'h08);
    expectRead(6'h01, 8'h00, "R2 status cleared");
    check("R2 busy", 32'(busy), 1);
    mstTxIdx = 5'd0; #1;
    check("R13 tx byte0", 32'(mstTxByte), 32'h34);
    mstTxIdx = 5'd1; #1;
    check("R13 tx byte1", 32'(mstTxByte), 32'h12);
    finish(5'h00, 8'h00);
    expectRead(6'h01, 8'h80, "R4 done ok");
    check("R4 busy low", 32'(busy), 0);

    // R5 word read little-endian, R6 count unchanged
    expectStart(8'h09, 7'h52, 8'h10, 6'd0, "R2 word read");
    hostWrite(6'h00, 8'h09);
    rxByte(5'd0, 8'hCD);
    rxByte(5'd1, 8'hAB);
    finish(5'h00, 8'h02);
    expectRead(6'h04, 8'hCD, "R5 low byte");
    expectRead(6'h05, 8'hAB, "R5 high byte");
    expectRead(6'h24, 8'h00, "R6 count kept on word read");

    // R7 clamp, R8 proc limit, R9 reject
    hostWrite(6'h24, 8'd40);
    expectRead(6'h24, 8'd32, "R7 count clamp");
    expectStart(8'h0D, 7'h52, 8'h10, 6'd31, "R8 block proc");
    hostWrite(6'h00, 8'h0D);
    hostWrite(6'h00, 8'h04);
    expectRead(6'h01, 8'h1A, "R9 busy code");
    expectRead(6'h00, 8'h0D, "R9 protocol kept");
    rxByte(5'd2, 8'h5A);
    finish(5'h10, 8'd5);
    expectRead(6'h01, 8'h90, "R4 nak code");
    expectRead(6'h24, 8'd5, "R6 block proc count");
    expectRead(6'h06, 8'h5A, "R5 rx index 2");

    // R6 block read clamp
    expectStart(8'h0B, 7'h52, 8'h10, 6'd5, "R2 block read");
    hostWrite(6'h00, 8'h0B);
    finish(5'h00, 8'd50);
    expectRead(6'h24, 8'd32, "R6 block read clamp");

    // R6 I2C block read keeps count
    hostWrite(6'h24, 8'd3);
    expectStart(8'h4B, 7'h52, 8'h10, 6'd3, "R8 i2c block");
    hostWrite(6'h00, 8'h4B);
    finish(5'h00, 8'd7);
    expectRead(6'h24, 8'd3, "R6 i2c block count kept");

    // R8 block write length
    expectStart(8'h0A, 7'h52, 8'h10, 6'd3, "R8 block write");
    hostWrite(6'h00, 8'h0A);
    finish(5'h00, 8'd0);
    expectRead(6'h01, 8'h80, "R4 block write done");

    // R10 unsupported
    hostWrite(6'h00, 8'h20);
    expectRead(6'h01, 8'h99, "R10 not supported");
    expectRead(6'h00, 8'h20, "R10 protocol stored");
    check("R10 busy low", 32'(busy), 0);

    // R11 ignored writes
    hostWrite(6'h01, 8'h55);
    expectRead(6'h01, 8'h99, "R11 status write ignored");
    rxByte(5'd0, 8'hEE);
    expectRead(6'h04, 8'hCD, "R11 idle rx ignored");

    // R12 alarm storage
    hostWrite(6'h25, 8'h3C);
    hostWrite(6'h26, 8'hC3);
    hostWrite(6'h27, 8'h7E);
    expectRead(6'h25, 8'h3C, "R12 alarm addr");
    expectRead(6'h26, 8'hC3, "R12 alarm data0");
    expectRead(6'h27, 8'h7E, "R12 alarm data1");

    repeat (4) @(posedge clk);
    check("R2 start missing", 32'(stQ.size()), 0);
    summary();
  end

endmodule